// File: doc/BRIEF.md
# Floating-Point Normalize Unit with Status Flags

This unit takes one floating-point operand per cycle and returns it in normalized form. The operand has an 8-bit two's-complement exponent in bits 39:32 and a 32-bit two's-complement mantissa in bits 31:0, with the sign in bit 31. The input mantissa is treated as unnormalized: its hidden bit is taken to be a copy of the sign rather than a constant one. The unit shifts the mantissa left until the bit after the sign differs from the sign. It takes the shift distance off the exponent and drops the hidden bit from the stored result.

The exponent code -128 (0x80) is reserved to mean zero. A zero input, a reserved-exponent input, and an exponent that falls to -128 or below after the adjustment all produce the canonical zero. Each of these cases has its own flag outcome. The result is registered and appears one cycle after the input strobe. The flags (negative, zero, overflow, underflow and a sticky underflow) are also registered. They change only when the caller marks the destination as a flag-updating register. The unit has no overflow-saturation mode.

Top module: `fpnorm_unit`

## Requirements
- R1: After reset, `out_vld`, `out_res` and all five flag outputs are 0.
- R2: An input accepted with `in_vld`=1 at a clock edge produces `out_vld`=1 and its result on `out_res` after that same edge. `out_vld` is 0 after an edge without `in_vld`, and `out_res` then keeps its previous value.
- R3: For an ordinary operand (exponent not 0x80, mantissa not 0), let c be the number of leading bits, counted from bit 30 downward, that equal the sign bit s, and let n = c+1. The result mantissa is s in bit 31, with bits 30:0 equal to the input bits 30:0 shifted left by n (zero-filled). The result exponent is the input exponent minus n.
- R4: An operand with exponent 0x80 and mantissa 0 gives result 0x80_00000000, with Z=1 and UF=0.
- R5: An operand with exponent 0x80 and a nonzero mantissa gives result 0x80_00000000, with Z=0 and UF=1.
- R6: An operand with mantissa 0 and any other exponent gives result 0x80_00000000, with Z=1 and UF=0.
- R7: When the adjusted exponent (input exponent minus n) is -128 or less, the result is forced to 0x80_00000000, with UF=1 and Z=1. An adjusted exponent of exactly -127 is kept as an ordinary result.
- R8: N equals the result sign for ordinary results and is 0 for every zero result. V is cleared on every flag update.
- R9: The flags change only at an edge where `in_vld`=1 and `in_flag_en`=1. Otherwise they hold, even though the result still updates.
- R10: LUF is set by any flag update that sets UF. It stays set through later updates that clear UF and is cleared only by reset.
- R11: A mantissa of all ones (-1) takes n=32 and gives mantissa 0x80000000 with exponent e-32, or the R7 zero if e-32 is -128 or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand strobe |
| in_flag_en | input | 1 | Destination updates flags |
| in_opnd | input | 40 | Exponent [39:32], mantissa [31:0] |
| out_vld | output | 1 | Result valid, one cycle after strobe |
| out_res | output | 40 | Normalized result |
| flg_n | output | 1 | Negative result |
| flg_z | output | 1 | Zero result |
| flg_v | output | 1 | Overflow (always cleared on update) |
| flg_uf | output | 1 | Underflow of this update |
| flg_luf | output | 1 | Sticky underflow |

## Verification
Two functions can fall in the same cycle: the exponent adjustment and the underflow override. A long shift on a small exponent makes the adjusted exponent cross the reserved code. The bench provokes this with single-bit and all-ones mantissas whose exponents are set so the adjusted exponent lands on -127, -128 and below. Each result is judged against an independent behavioural model for both the forced zero and its Z/UF pair. A second overlap is a reserved-exponent operand whose mantissa would otherwise normalize; the check confirms that the reserved rule wins, with Z=0 and UF=1.

// File: rtl/fpnorm_pkg.sv
package fpnorm_pkg;
  // outcome class of one normalize operation
  typedef enum logic [1:0] {
    CLS_NORMAL = 2'd0,  // ordinary normalized result
    CLS_ZERO   = 2'd1,  // zero mantissa or reserved exponent with zero mantissa
    CLS_RSV_NZ = 2'd2,  // reserved exponent, nonzero mantissa
    CLS_UNDER  = 2'd3   // adjusted exponent hit the reserved code
  } norm_cls_e;
endpackage

// File: rtl/norm_lsc.sv
// leading sign-copy counter: how many top bits of 'bits' equal 'sgn'
module norm_lsc #(
  parameter int W  = 31,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits,
  input  logic          sgn,
  output logic [CW-1:0] cnt
);
  logic [W-1:0] dif;

  for (genvar i = 0; i < W; i++) begin : g_dif
    assign dif[i] = bits[i] ^ sgn;
  end

  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (dif[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/norm_core.sv
module norm_core
  import fpnorm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 32,
  localparam int OP_W = EXP_W + MAN_W
) (
  input  logic [OP_W-1:0] opnd,
  output logic [OP_W-1:0] res,
  output norm_cls_e       cls,
  output logic            neg
);
  localparam int FW = MAN_W - 1;
  localparam int CW = $clog2(FW + 1);
  localparam int SW = CW + 1;
  localparam int DW = EXP_W + SW + 1;
  localparam logic signed [DW-1:0] EMIN = DW'(-(2 ** (EXP_W - 1)));
  localparam logic [EXP_W-1:0] ZEXP = {1'b1, {(EXP_W-1){1'b0}}};

  logic [EXP_W-1:0]        e;
  logic [MAN_W-1:0]        m;
  logic                    s;
  logic [CW-1:0]           lz;
  logic [SW-1:0]           shamt;
  logic [FW-1:0]           frac_sh;
  logic signed [DW-1:0]    e_ext, n_ext, d;
  logic                    rsv, mzero, under;

  assign e = opnd[OP_W-1:MAN_W];
  assign m = opnd[MAN_W-1:0];
  assign s = m[MAN_W-1];

  norm_lsc #(.W(FW)) u_lsc (
    .bits (m[FW-1:0]),
    .sgn  (s),
    .cnt  (lz)
  );

  always_comb begin
    shamt   = SW'(lz) + SW'(1);
    frac_sh = m[FW-1:0] << shamt;
    e_ext   = {{(DW-EXP_W){e[EXP_W-1]}}, e};
    n_ext   = {{(DW-SW){1'b0}}, shamt};
    d       = e_ext - n_ext;
    rsv     = (e == ZEXP);
    mzero   = (m == '0);
    under   = (d <= EMIN);
  end

  always_comb begin
    res = {ZEXP, {MAN_W{1'b0}}};
    neg = 1'b0;
    if (rsv) begin
      cls = mzero ? CLS_ZERO : CLS_RSV_NZ;
    end else if (mzero) begin
      cls = CLS_ZERO;
    end else if (under) begin
      cls = CLS_UNDER;
    end else begin
      cls = CLS_NORMAL;
      res = {d[EXP_W-1:0], s, frac_sh};
      neg = s;
    end
  end
endmodule

// File: rtl/norm_flags.sv
module norm_flags
  import fpnorm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      upd,
  input  norm_cls_e cls,
  input  logic      neg,
  output logic      f_n,
  output logic      f_z,
  output logic      f_v,
  output logic      f_uf,
  output logic      f_luf
);
  logic nz_n, nz_z, nz_uf;

  always_comb begin
    nz_n  = 1'b0;
    nz_z  = 1'b0;
    nz_uf = 1'b0;
    unique case (cls)
      CLS_NORMAL: nz_n  = neg;
      CLS_ZERO:   nz_z  = 1'b1;
      CLS_RSV_NZ: nz_uf = 1'b1;
      CLS_UNDER: begin
        nz_z  = 1'b1;
        nz_uf = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_n   <= 1'b0;
      f_z   <= 1'b0;
      f_v   <= 1'b0;
      f_uf  <= 1'b0;
      f_luf <= 1'b0;
    end else if (upd) begin
      f_n   <= nz_n;
      f_z   <= nz_z;
      f_v   <= 1'b0;
      f_uf  <= nz_uf;
      f_luf <= f_luf | nz_uf;
    end
  end

  // R9: flags hold when no update
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable({f_n, f_z, f_v, f_uf, f_luf}));
  // R10: sticky underflow never drops outside reset
  p_luf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    f_luf |=> f_luf);
  // R10: an underflow update leaves LUF set
  p_luf_set_r10: assert property (@(posedge clk) disable iff (rst)
    (upd && (cls == CLS_UNDER || cls == CLS_RSV_NZ)) |=> f_luf);
  // R8: negative and zero never together
  p_nz_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(f_n && f_z));
endmodule

// File: rtl/fpnorm_unit.sv
module fpnorm_unit
  import fpnorm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 32,
  localparam int OP_W = EXP_W + MAN_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic            in_flag_en,
  input  logic [OP_W-1:0] in_opnd,
  output logic            out_vld,
  output logic [OP_W-1:0] out_res,
  output logic            flg_n,
  output logic            flg_z,
  output logic            flg_v,
  output logic            flg_uf,
  output logic            flg_luf
);
  localparam logic [EXP_W-1:0] ZEXP = {1'b1, {(EXP_W-1){1'b0}}};

  logic [OP_W-1:0] c_res;
  norm_cls_e       c_cls;
  logic            c_neg;

  norm_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_core (
    .opnd (in_opnd),
    .res  (c_res),
    .cls  (c_cls),
    .neg  (c_neg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_res <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_res <= c_res;
    end
  end

  norm_flags u_flags (
    .clk   (clk),
    .rst   (rst),
    .upd   (in_vld & in_flag_en),
    .cls   (c_cls),
    .neg   (c_neg),
    .f_n   (flg_n),
    .f_z   (flg_z),
    .f_v   (flg_v),
    .f_uf  (flg_uf),
    .f_luf (flg_luf)
  );

  // R2: one-cycle result strobe
  p_vld_lat_r2: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  p_vld_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!out_vld && $stable(out_res)));
  // R7: a result carrying the reserved exponent is the canonical zero
  p_zero_canon_r7: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_res[OP_W-1:MAN_W] == ZEXP) |-> (out_res[MAN_W-1:0] == '0));
endmodule

// File: tb/tb_fpnorm_unit.sv
module tb_fpnorm_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic        in_flag_en = 1'b0;
  logic [39:0] in_opnd = '0;
  logic        out_vld;
  logic [39:0] out_res;
  logic        flg_n, flg_z, flg_v, flg_uf, flg_luf;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expected flag state
  logic e_n = 0, e_z = 0, e_uf = 0, e_luf = 0;
  logic [39:0] e_res = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpnorm_unit dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_flag_en(in_flag_en),
    .in_opnd(in_opnd), .out_vld(out_vld), .out_res(out_res),
    .flg_n(flg_n), .flg_z(flg_z), .flg_v(flg_v), .flg_uf(flg_uf),
    .flg_luf(flg_luf)
  );

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model of the requirements
  function automatic void ref_norm(input logic [39:0] op, output logic [39:0] r,
                                   output logic n, output logic z, output logic uf);
    int e, cnt, sh, ed;
    logic [31:0] m;
    logic s;
    logic [63:0] t;
    bit stop;
    e = int'($signed(op[39:32]));
    m = op[31:0];
    s = m[31];
    r = {8'h80, 32'h0};
    n = 0; z = 0; uf = 0;
    if (e == -128) begin
      z = (m == 0); uf = (m != 0);
    end else if (m == 0) begin
      z = 1;
    end else begin
      cnt = 0; stop = 0;
      for (int i = 30; i >= 0; i--) begin
        if (!stop && m[i] == s) cnt++;
        else stop = 1;
      end
      sh = cnt + 1;
      ed = e - sh;
      if (ed < -127) begin
        z = 1; uf = 1;
      end else begin
        t = {33'h0, m[30:0]} << sh;
        r = {ed[7:0], s, t[30:0]};
        n = s;
      end
    end
  endfunction

  // apply one operand and check result plus flags
  task automatic apply(input logic [39:0] op, input logic fen, input string tag);
    logic [39:0] r;
    logic n, z, uf;
    ref_norm(op, r, n, z, uf);
    @(negedge clk);
    in_vld = 1; in_opnd = op; in_flag_en = fen;
    @(negedge clk);
    in_vld = 0; in_flag_en = 0;
    e_res = r;
    if (fen) begin
      e_n = n; e_z = z; e_uf = uf; e_luf = e_luf | uf;
    end
    chk({tag, " R2 vld"}, 40'(out_vld), 40'(1));
    chk({tag, " res"}, out_res, e_res);
    chk({tag, " flags N,Z,V,UF,LUF R8 R9"},
        40'({flg_n, flg_z, flg_v, flg_uf, flg_luf}),
        40'({e_n, e_z, 1'b0, e_uf, e_luf}));
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    e_n = 0; e_z = 0; e_uf = 0; e_luf = 0; e_res = '0;
    chk("R1 reset outputs",
        {33'h0, out_vld, flg_n, flg_z, flg_v, flg_uf, flg_luf, 1'b0},
        40'h0);
    chk("R1 reset result", out_res, 40'h0);
  endtask

  task automatic t_normal;
    apply({8'd5, 32'h4000_0000}, 1, "R3 shift1");
    chk("R3 shift1 exact", out_res, {8'd4, 32'h0000_0000});
    apply({8'd10, 32'h0000_0001}, 1, "R3 bit0");
    chk("R3 bit0 exact", out_res, {8'hEB, 32'h0000_0000});
    apply({8'd0, 32'hC123_4567}, 1, "R3 neg");
    apply({8'h7F, 32'h2468_ACE1}, 1, "R3 maxexp");
    apply({8'hF0, 32'hBFFF_FFFF}, 1, "R3 negshift1");
  endtask

  task automatic t_idle;
    logic [39:0] held;
    held = out_res;
    @(negedge clk);
    chk("R2 idle vld", 40'(out_vld), 40'(0));
    chk("R2 idle hold", out_res, held);
  endtask

  task automatic t_reserved;
    apply({8'h80, 32'h0}, 1, "R4 rsv zero");
    apply({8'h80, 32'h4000_0000}, 1, "R5 rsv nonzero");
    chk("R5 Z clear UF set", 40'({flg_z, flg_uf}), 40'(2'b01));
  endtask

  task automatic t_zero_man;
    apply({8'd33, 32'h0}, 1, "R6 zero man");
    apply({8'hFF, 32'h0}, 1, "R6 zero man negexp");
  endtask

  task automatic t_underflow;
    apply({8'hA0, 32'h0000_0001}, 1, "R7 boundary -127");
    chk("R7 keep -127", out_res, {8'h81, 32'h0});
    apply({8'h9F, 32'h0000_0001}, 1, "R7 boundary -128");
    apply({8'h9C, 32'h0000_0001}, 1, "R7 deep");
    apply({8'h81, 32'h4000_0000}, 1, "R7 min exp shift1");
  endtask

  task automatic t_all_ones;
    apply({8'd40, 32'hFFFF_FFFF}, 1, "R11 ones");
    chk("R11 ones exact", out_res, {8'd8, 32'h8000_0000});
    apply({8'hA0, 32'hFFFF_FFFF}, 1, "R11 ones under");
  endtask

  task automatic t_flag_gate;
    apply({8'd3, 32'h8000_0001}, 1, "R9 set N");
    apply({8'd3, 32'h0}, 0, "R9 no-update zero");
    chk("R9 N held", 40'({flg_n, flg_z}), 40'(2'b10));
  endtask

  task automatic t_luf;
    t_reset();
    apply({8'h80, 32'h1}, 0, "R10 gated uf");
    chk("R10 no set when gated", 40'(flg_luf), 40'(0));
    apply({8'h80, 32'h1}, 1, "R10 uf");
    apply({8'd2, 32'h1234_5678}, 1, "R10 after normal");
    chk("R10 sticky", 40'({flg_uf, flg_luf}), 40'(2'b01));
    t_reset();
  endtask

  task automatic t_random;
    logic [39:0] op;
    void'($urandom(32'h5eed));
    for (int k = 0; k < 300; k++) begin
      op = {$urandom(), $urandom()};
      if (k % 7 == 0) op[31:0] = op[31:0] >> (k % 32);
      apply(op, 1'($urandom() & 1), "R3 random");
    end
  endtask

  initial begin
    t_reset();
    t_normal();
    t_idle();
    t_reserved();
    t_zero_man();
    t_underflow();
    t_all_ones();
    t_flag_gate();
    t_luf();
    t_random();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule